// File: doc/BRIEF.md
# SD Card Single-Sector Transfer Engine

This block moves one 512-byte sector between a local byte stream and an SD card that has already been brought up in SPI mode. The host pulses `start` with a block number, a direction select and a flag that says whether the card is high-capacity. The engine then owns the SPI pins. It frames the single-block read or write command, waits for the card's answer and streams the sector. On a write it checks the card's data response and waits out the programming busy time. It then releases chip select and reports a status code with a one-cycle `done` pulse.

Sector bytes cross the block's edge on valid/ready ports. On a read, `rd_valid` rises with each received byte. The byte stays on `rd_data` until `rd_ready` is seen, and no further SPI clock is issued while it waits. On a write, `wd_ready` is high whenever the engine can take the next byte. If `wd_valid` stays low, the shifter waits between bytes with SCLK parked low. A transfer always uses exactly 512 handshakes. The SPI bit timing is set by a half-period parameter. A cycle budget, one second of the system clock by default, starts at `start` and is checked at every byte boundary.

Top module: `sd_sector_xfer`

## Requirements
- R1: After reset and whenever no transfer is running, `cs_n` is 1, `sclk` is 0, `done` is 0, `rd_valid` is 0 and `wd_ready` is 0.
- R2: A transfer opens with `cs_n` low and one 0xFF byte. Then comes the command byte 0x40 OR index (read index 17 gives 0x51, write index 24 gives 0x58), four argument bytes most significant first, and a trailer of 0xFF. Bits go out MSB first on `mosi`, change while `sclk` is low and are sampled by the card on the rising edge.
- R3: When `hc_card` is 0 the argument is `blk_num` shifted left by 9. When `hc_card` is 1 it is `blk_num` unchanged.
- R4: 0xFF bytes after the command are skipped. If the first other byte (the R1 response) is nonzero, the transfer ends with status 3, and no data byte moves on either port.
- R5: On a read, the engine polls until a non-0xFF byte (the start token) arrives. It then delivers the next 512 bytes in order on the read port, clocks two further bytes and discards them, and ends with status 0.
- R6: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` hold and `sclk` stays 0.
- R7: On a write, the engine sends 0xFE, then the 512 bytes taken from the write port in order, then two 0xFF bytes.
- R8: While `wd_ready` is 1 and `wd_valid` is 0, `sclk` stays 0. A write takes exactly 512 handshakes.
- R9: After the write data, the first non-0xFF byte must have its low five bits equal to 00101. Any other value ends the transfer at once with status 2.
- R10: After an accepted data response, the engine keeps clocking bytes until one is nonzero, then ends with status 0.
- R11: If `TIMEOUT_CYCLES` clocks have passed since `start`, the next completed byte ends the transfer with status 1.
- R12: `done` is a one-cycle pulse, `status` is valid with it, and `cs_n` is already 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer (taken while idle) |
| write | input | 1 | 1 = write sector, 0 = read sector |
| hc_card | input | 1 | Card is high-capacity (block addressed) |
| blk_num | input | 32 | Sector number |
| done | output | 1 | End-of-transfer pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 write rejected, 3 command error |
| wd_valid | input | 1 | Write byte available |
| wd_ready | output | 1 | Engine takes a write byte |
| wd_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes a read byte |
| rd_data | output | 8 | Read byte |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Card select, active low |
| mosi | output | 1 | Data to card |
| miso | input | 1 | Data from card |

## Verification
A sequencer that leaves a phase one byte early or late changes how many bytes the card model counts after the command. It also changes the byte count on the data port. Both counts are checked when `done` arrives, so a slip shows within one transfer. A wrong response test shows up as a status code that does not match the card's scripted reply. A shifter that clocks during a stall shows up as an SCLK edge while a handshake is pending, and that is caught in the very next cycle.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  typedef enum logic [3:0] {
    XS_IDLE, XS_CMD, XS_R1, XS_RTOK, XS_RDAT, XS_RCRC,
    XS_WTOK, XS_WDAT, XS_WCRC, XS_WRSP, XS_WBSY, XS_END
  } xfer_st_t;

  localparam logic [1:0] ERR_OK   = 2'd0;
  localparam logic [1:0] ERR_TMO  = 2'd1;
  localparam logic [1:0] ERR_WREJ = 2'd2;
  localparam logic [1:0] ERR_R1   = 2'd3;

  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam logic [7:0] START_TOKEN = 8'hFE;
  localparam logic [5:0] OP_READ     = 6'd17;
  localparam logic [5:0] OP_WRITE    = 6'd24;
  localparam logic [4:0] ACCEPT_CODE = 5'b00101;
endpackage

// File: rtl/sdx_spi_byte.sv
module sdx_spi_byte #(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       fin
);
  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(HALF_CYC - 1);

  logic          act;
  logic [PW-1:0] ph;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      ph   <= '0;
      bitn <= '0;
      sh   <= '0;
      rx   <= '0;
      sclk <= 1'b0;
      mosi <= 1'b1;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !act) begin
        act  <= 1'b1;
        sh   <= tx;
        mosi <= tx[7];
        bitn <= '0;
        ph   <= '0;
      end else if (act) begin
        if (ph == PH_LAST) begin
          ph <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              act  <= 1'b0;
              fin  <= 1'b1;
              mosi <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b1};
              mosi <= sh[6];
            end
          end
        end else begin
          ph <= ph + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sdx_budget.sv
module sdx_budget #(
  parameter int LIMIT = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TOP = TW'(LIMIT);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (cnt != TOP)  cnt <= cnt + TW'(1);
  end

  assign expired = (cnt == TOP);
endmodule

// File: rtl/sd_sector_xfer.sv
module sd_sector_xfer
  import sdx_pkg::*;
#(
  parameter int HALF_CYC       = 2,
  parameter int TIMEOUT_CYCLES = 100_000_000,
  parameter int SECTOR_BYTES   = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        write,
  input  logic        hc_card,
  input  logic [31:0] blk_num,
  output logic        done,
  output logic [1:0]  status,
  input  logic        wd_valid,
  output logic        wd_ready,
  input  logic [7:0]  wd_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [7:0]  rd_data,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  localparam int CW  = $clog2(SECTOR_BYTES + 1);
  localparam int ASH = $clog2(SECTOR_BYTES);
  localparam logic [CW-1:0] LAST_IDX   = CW'(SECTOR_BYTES - 1);
  localparam logic [CW-1:0] FULL_CNT   = CW'(SECTOR_BYTES);
  localparam logic [CW-1:0] FRAME_LAST = CW'(6);
  localparam logic [CW-1:0] ONE        = CW'(1);

  xfer_st_t    st;
  logic [CW-1:0] cnt;
  logic        inflight, is_wr;
  logic [31:0] arg_q;
  logic        want, go, fin, tmo;
  logic [7:0]  tx_b, rx_b;
  logic [5:0]  op;

  assign op = is_wr ? OP_WRITE : OP_READ;

  // byte to send next and whether one may be started
  always_comb begin
    want = 1'b0;
    tx_b = FILL_BYTE;
    case (st)
      XS_CMD: begin
        want = 1'b1;
        case (cnt[2:0])
          3'd1:    tx_b = {2'b01, op};
          3'd2:    tx_b = arg_q[31:24];
          3'd3:    tx_b = arg_q[23:16];
          3'd4:    tx_b = arg_q[15:8];
          3'd5:    tx_b = arg_q[7:0];
          default: tx_b = FILL_BYTE;
        endcase
      end
      XS_R1, XS_RTOK, XS_RCRC, XS_WCRC, XS_WRSP, XS_WBSY: want = 1'b1;
      XS_WTOK: begin
        want = 1'b1;
        tx_b = START_TOKEN;
      end
      XS_RDAT: want = !rd_valid && (cnt < FULL_CNT);
      XS_WDAT: begin
        want = wd_valid;
        tx_b = wd_data;
      end
      default: ;
    endcase
  end

  assign go       = want && !inflight;
  assign wd_ready = (st == XS_WDAT) && !inflight;

  sdx_spi_byte #(.HALF_CYC(HALF_CYC)) u_phy (
    .clk(clk), .rst_n(rst_n), .go(go), .tx(tx_b), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rx(rx_b), .fin(fin)
  );

  sdx_budget #(.LIMIT(TIMEOUT_CYCLES)) u_budget (
    .clk(clk), .rst_n(rst_n), .clr(start && st == XS_IDLE), .expired(tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= XS_IDLE;
      cnt      <= '0;
      inflight <= 1'b0;
      is_wr    <= 1'b0;
      arg_q    <= '0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      status   <= ERR_OK;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= 1'b0;
      if (go) inflight <= 1'b1;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (st)
        XS_IDLE: if (start) begin
          is_wr  <= write;
          arg_q  <= hc_card ? blk_num : (blk_num << ASH);
          cs_n   <= 1'b0;
          cnt    <= '0;
          status <= ERR_OK;
          st     <= XS_CMD;
        end
        XS_END: begin
          cs_n <= 1'b1;
          done <= 1'b1;
          st   <= XS_IDLE;
        end
        default: begin
          if (fin) begin
            inflight <= 1'b0;
            if (tmo) begin
              status <= ERR_TMO;
              st     <= XS_END;
            end else begin
              case (st)
                XS_CMD: if (cnt == FRAME_LAST) begin
                  st  <= XS_R1;
                  cnt <= '0;
                end else cnt <= cnt + ONE;
                XS_R1: if (rx_b != FILL_BYTE) begin
                  if (rx_b != 8'h00) begin
                    status <= ERR_R1;
                    st     <= XS_END;
                  end else st <= is_wr ? XS_WTOK : XS_RTOK;
                end
                XS_RTOK: if (rx_b != FILL_BYTE) begin
                  st  <= XS_RDAT;
                  cnt <= '0;
                end
                XS_RDAT: begin
                  rd_data  <= rx_b;
                  rd_valid <= 1'b1;
                  cnt      <= cnt + ONE;
                end
                XS_RCRC: if (cnt == ONE) st <= XS_END;
                         else cnt <= cnt + ONE;
                XS_WTOK: begin
                  st  <= XS_WDAT;
                  cnt <= '0;
                end
                XS_WDAT: if (cnt == LAST_IDX) begin
                  st  <= XS_WCRC;
                  cnt <= '0;
                end else cnt <= cnt + ONE;
                XS_WCRC: if (cnt == ONE) st <= XS_WRSP;
                         else cnt <= cnt + ONE;
                XS_WRSP: if (rx_b != FILL_BYTE) begin
                  if (rx_b[4:0] != ACCEPT_CODE) begin
                    status <= ERR_WREJ;
                    st     <= XS_END;
                  end else st <= XS_WBSY;
                end
                XS_WBSY: if (rx_b != 8'h00) st <= XS_END;
                default: ;
              endcase
            end
          end else if (st == XS_RDAT && cnt == FULL_CNT && !rd_valid) begin
            st  <= XS_RCRC;
            cnt <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sd_sector_xfer_chk.sv
module sd_sector_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       wd_valid,
  input logic       wd_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       sclk,
  input logic       cs_n
);
  assert_sclk_parked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_rd_noclk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !sclk);

  assert_wr_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_ready && !wd_valid) |=> !sclk);

  assert_ports_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wd_ready));

  assert_done_deselect_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sd_sector_xfer sd_sector_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .wd_valid(wd_valid),
  .wd_ready(wd_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/sim_sd_sector_xfer.sv
module sim_sd_sector_xfer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 1;
  localparam int TMO  = 16000;
  localparam int NB   = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, write = 0, hc_card = 0;
  logic [31:0] blk_num = '0;
  logic done, wd_ready, rd_valid, sclk, cs_n, mosi;
  logic [1:0] status;
  logic wd_valid = 0, rd_ready = 0;
  logic [7:0] wd_data = '0, rd_data;
  logic miso = 1'b1;

  sd_sector_xfer #(.HALF_CYC(HALF), .TIMEOUT_CYCLES(TMO), .SECTOR_BYTES(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .write(write), .hc_card(hc_card),
    .blk_num(blk_num), .done(done), .status(status), .wd_valid(wd_valid),
    .wd_ready(wd_ready), .wd_data(wd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rpat(int i);
    return 8'((i * 5) + (i >> 8) + 1);
  endfunction
  function automatic logic [7:0] wpat(int i);
    return 8'((i * 11) ^ 8'h5A ^ (i >> 7));
  endfunction

  // ---------------- behavioural card ----------------
  int c_r1_delay, c_tok_delay, c_rsp_delay, c_busy;
  logic [7:0] c_r1, c_resp;
  bit c_silent;
  int cst, ci, pre_cnt, after_cnt, wi, post_rsp, bc;
  logic [7:0] cmdb [6];
  logic [7:0] wcap [NB];
  logic [7:0] crcw [2];
  logic [7:0] q [$];
  logic [7:0] outb, rxsh;
  logic last_sclk = 1'b0, last_cs = 1'b1;

  task automatic card_byte(input logic [7:0] b);
    case (cst)
      0: if (b[7:6] == 2'b01) begin cmdb[0] = b; ci = 1; cst = 1; end
         else pre_cnt++;
      1: begin
        cmdb[ci] = b; ci++;
        if (ci == 6) begin
          after_cnt = 0;
          cst = 2;
          if (!c_silent) begin
            repeat (c_r1_delay) q.push_back(8'hFF);
            q.push_back(c_r1);
            if (c_r1 == 8'h00) begin
              if (cmdb[0] == 8'h51) begin
                repeat (c_tok_delay) q.push_back(8'hFF);
                q.push_back(8'hFE);
                for (int i = 0; i < NB; i++) q.push_back(rpat(i));
                q.push_back(8'h5A); q.push_back(8'hA5);
              end else cst = 3;
            end
          end
        end
      end
      2: after_cnt++;
      3: if (b == 8'hFE) begin cst = 4; wi = 0; end
      4: begin wcap[wi] = b; wi++; if (wi == NB) cst = 5; end
      5: begin crcw[0] = b; cst = 6; end
      6: begin
        crcw[1] = b; cst = 7; post_rsp = 0;
        repeat (c_rsp_delay) q.push_back(8'hFF);
        q.push_back(c_resp);
        if (c_resp[4:0] == 5'b00101) repeat (c_busy) q.push_back(8'h00);
      end
      default: post_rsp++;
    endcase
  endtask

  always @(sclk or cs_n) begin
    if (last_cs && !cs_n) begin
      cst = 0; ci = 0; pre_cnt = 0; after_cnt = 0; wi = 0; post_rsp = 0;
      bc = 0; q.delete(); outb = 8'hFF; miso = 1'b1;
    end else if (sclk && !last_sclk) begin
      rxsh = {rxsh[6:0], mosi};
      bc++;
      if (bc == 8) begin
        bc = 0;
        card_byte(rxsh);
        outb = (q.size() > 0) ? q.pop_front() : 8'hFF;
      end
    end else if (!sclk && last_sclk) begin
      miso = outb[7 - bc];
    end
    last_sclk = sclk;
    last_cs = cs_n;
  end

  // ---------------- transfer driver ----------------
  logic [7:0] rcap [NB];
  int nrd, widx, t_start, t_done;
  logic [1:0] got_status;

  task automatic idle_check(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(cs_n && !sclk && !done && !rd_valid && !wd_ready, "R1", "idle outputs",
          {cs_n, sclk, done, rd_valid, wd_ready}, 5'b10000);
    end
  endtask

  task automatic xfer(input bit w, input bit hc, input logic [31:0] blk,
                      input bit bp, input bit stall);
    bit prev_stall;
    nrd = 0; widx = 0; prev_stall = 0;
    @(negedge clk);
    write = w; hc_card = hc; blk_num = blk; start = 1'b1;
    t_start = cyc;
    for (int k = 0; k < TMO + 4000; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (prev_stall) chk(!sclk, "R8", "sclk during write stall", sclk, 0);
      if (rd_valid && !rd_ready) chk(!sclk, "R6", "sclk while read held", sclk, 0);
      rd_ready = bp ? (cyc % 3 != 0) : 1'b1;
      if (rd_valid && rd_ready) begin
        if (nrd < NB) rcap[nrd] = rd_data;
        nrd++;
      end
      wd_valid = stall ? (cyc % 4 != 1) : 1'b1;
      wd_data = wpat(widx);
      prev_stall = wd_ready && !wd_valid;
      if (wd_valid && wd_ready) widx++;
      if (done) begin
        got_status = status;
        t_done = cyc;
        chk(cs_n, "R12", "cs_n at done", cs_n, 1);
        break;
      end
    end
    rd_ready = 1'b0; wd_valid = 1'b0;
    chk(done, "R12", "done seen", done, 1);
  endtask

  task automatic chk_frame(input logic [7:0] opb, input logic [31:0] arg);
    chk(pre_cnt == 1, "R2", "leading fill bytes", pre_cnt, 1);
    chk(cmdb[0] == opb, "R2", "command byte", cmdb[0], opb);
    chk({cmdb[1], cmdb[2], cmdb[3], cmdb[4]} == arg, "R3", "argument",
        {cmdb[1], cmdb[2], cmdb[3], cmdb[4]}, arg);
    chk(cmdb[5] == 8'hFF, "R2", "trailer byte", cmdb[5], 8'hFF);
  endtask

  task automatic chk_read_data(input string tag);
    int bad = 0, first = -1;
    chk(nrd == NB, tag, "read byte count", nrd, NB);
    for (int i = 0; i < NB; i++)
      if (rcap[i] !== rpat(i)) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, tag, "read data first bad index", first, -1);
  endtask

  task automatic set_card(input int r1d, input logic [7:0] r1, input int tokd,
                          input int rspd, input logic [7:0] rsp, input int busy,
                          input bit silent);
    c_r1_delay = r1d; c_r1 = r1; c_tok_delay = tokd;
    c_rsp_delay = rspd; c_resp = rsp; c_busy = busy; c_silent = silent;
  endtask

  initial begin
    set_card(0, 8'h00, 0, 0, 8'hE5, 0, 0);
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !done && !rd_valid && !wd_ready, "R1", "reset outputs",
        {cs_n, sclk, done, rd_valid, wd_ready}, 5'b10000);
    rst_n = 1'b1;
    idle_check(4);

    // R5 R3: standard-capacity read with response and token delays
    set_card(2, 8'h00, 3, 0, 8'hE5, 0, 0);
    xfer(0, 0, 32'h0001_2345, 0, 0);
    chk(got_status == 2'd0, "R5", "read status", got_status, 0);
    chk_frame(8'h51, 32'h0001_2345 << 9);
    chk_read_data("R5");
    chk(after_cnt == 2 + 1 + 3 + 1 + NB + 2, "R5", "bytes clocked after command",
        after_cnt, 2 + 1 + 3 + 1 + NB + 2);
    idle_check(3);

    // R6 R3: high-capacity read under back-pressure
    set_card(0, 8'h00, 0, 0, 8'hE5, 0, 0);
    xfer(0, 1, 32'h00AB_CDEF, 1, 0);
    chk(got_status == 2'd0, "R6", "read status", got_status, 0);
    chk_frame(8'h51, 32'h00AB_CDEF);
    chk_read_data("R6");
    chk(after_cnt == 1 + 1 + NB + 2, "R5", "bytes clocked after command",
        after_cnt, 1 + 1 + NB + 2);
    idle_check(3);

    // R4: command rejected
    set_card(1, 8'h05, 0, 0, 8'hE5, 0, 0);
    xfer(0, 0, 32'd9, 0, 0);
    chk(got_status == 2'd3, "R4", "command error status", got_status, 3);
    chk(nrd == 0, "R4", "no read bytes", nrd, 0);
    chk(after_cnt == 2, "R4", "bytes clocked after command", after_cnt, 2);
    idle_check(3);

    // R7 R8 R10: standard-capacity write with stalls and busy
    set_card(1, 8'h00, 0, 1, 8'hE5, 5, 0);
    xfer(1, 0, 32'd7, 0, 1);
    chk(got_status == 2'd0, "R10", "write status", got_status, 0);
    chk_frame(8'h58, 32'd7 << 9);
    chk(widx == NB, "R8", "write handshakes", widx, NB);
    chk(wi == NB, "R7", "card data bytes", wi, NB);
    begin
      int bad = 0, first = -1;
      for (int i = 0; i < NB; i++)
        if (wcap[i] !== wpat(i)) begin bad++; if (first < 0) first = i; end
      chk(bad == 0, "R7", "write data first bad index", first, -1);
    end
    chk(crcw[0] == 8'hFF && crcw[1] == 8'hFF, "R7", "trailing bytes",
        {crcw[0], crcw[1]}, 16'hFFFF);
    chk(post_rsp == 1 + 1 + 5 + 1, "R10", "bytes polled after data", post_rsp, 8);
    idle_check(3);

    // R9: write rejected by data response
    set_card(0, 8'h00, 0, 2, 8'h0B, 4, 0);
    xfer(1, 1, 32'h0000_0100, 0, 0);
    chk(got_status == 2'd2, "R9", "write rejected status", got_status, 2);
    chk_frame(8'h58, 32'h0000_0100);
    chk(post_rsp == 2 + 1, "R9", "bytes polled after data", post_rsp, 3);
    idle_check(3);

    // R11: card never answers
    set_card(0, 8'hFF, 0, 0, 8'hE5, 0, 1);
    xfer(0, 1, 32'd3, 0, 0);
    chk(got_status == 2'd1, "R11", "timeout status", got_status, 1);
    chk(t_done - t_start >= TMO && t_done - t_start <= TMO + 40, "R11",
        "timeout latency", t_done - t_start, TMO);
    idle_check(3);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk(0, "R12", "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule